// File: doc/BRIEF.md
# Memory Data-Bus Lane Tester

This block is a built-in self-test engine for the data lines of a 64-bit memory bus. On a start pulse it runs a fixed series of twelve test words through a simple request/accept memory port. Each word has three steps. The word is written to a target location. A decoy constant is then written to the neighbouring location, so that charge left on the bus cannot stand in for a broken line. Finally the target is read back once, and that single captured word is compared with what was written.

A mismatch does not stop the run: all twelve words are always tried. At the end the engine pulses a done flag. It also offers a sticky fail flag and a record of the first miscompare, which holds the address, the word written and the word observed. The twelve words are built by logic, not by a table. Half are masks in which each bit copies one bit of its own lane number. The other half are the bitwise inverses of those masks. With these words, every pair of lines is driven to opposite levels in some test, whatever the board routing. When a byte lane is open, its byte in the observed word carries the decoy's byte.

States: `ST_IDLE` (waiting), `ST_WR_PAT` (write the test word to the target), `ST_WR_DECOY` (write the decoy to target+1), `ST_RD_REQ` (issue the single read of the target), `ST_RD_WAIT` (wait for read data and compare), `ST_FINISH` (one-cycle done). Transitions:
- start: `ST_IDLE`→`ST_WR_PAT`
- pattern accepted: `ST_WR_PAT`→`ST_WR_DECOY`
- decoy accepted: `ST_WR_DECOY`→`ST_RD_REQ`
- read accepted: `ST_RD_REQ`→`ST_RD_WAIT`
- data back, more words: `ST_RD_WAIT`→`ST_WR_PAT`
- data back, last word: `ST_RD_WAIT`→`ST_FINISH`
- done: `ST_FINISH`→`ST_IDLE`

Top module: `dbus_lane_tester`

## Requirements
- R1: After reset, mem_req_o, busy_o, done_o and fail_o are low, and err_addr_o, err_exp_o and err_obs_o are zero.
- R2: A start_i pulse in idle latches base_addr_i and begins a run. A start_i pulse during a run has no effect on the accesses issued or the results.
- R3: Word k (k = 0..5) has bit b set when bit k of b is 1, which gives AAAA…, CCCC…, F0F0…, FF00…, FFFF0000…, FFFFFFFF00000000. Word k (k = 6..11) is the inverse of word 11−k. The words run in order k = 0..11.
- R4: For every word, the accepted accesses are exactly these, in this order: a write of the word to the base address, a write of 0x0123456789ABCDEF to base+1 (modulo 2^ADDR_W), then one read of the base address.
- R5: A request holds mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o steady until mem_ack_i. The read data is taken from the single mem_rvalid_i pulse that follows the accepted read, for any latency.
- R6: All twelve words are run even after a mismatch. done_o is high for exactly one cycle, the cycle after the twelfth read data returns.
- R7: fail_o is set if any captured read word differs from the word written, and it stays set for the rest of the run.
- R8: On the first mismatch of a run, err_addr_o, err_exp_o and err_obs_o take the base address, the word written and the word observed. Later mismatches do not change them. With no mismatch they stay zero.
- R9: fail_o and the error record hold after done_o until the next accepted start, which clears them.
- R10: busy_o is high from the cycle after an accepted start through the done_o cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| base_addr_i | input | ADDR_W | Word address of the target location |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Request word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | Request accepted |
| mem_rdata_i | input | DATA_W | Read data |
| mem_rvalid_i | input | 1 | Read data valid |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Sticky mismatch flag |
| err_addr_o | output | ADDR_W | Address of first mismatch |
| err_exp_o | output | DATA_W | Word written at first mismatch |
| err_obs_o | output | DATA_W | Word observed at first mismatch |

## Verification
The engine runs against a healthy memory, against single lines stuck high or low, and against an open byte lane that returns whatever was last driven on the bus. A stuck line is told apart by which test word fails first and by the one-bit difference in the observed word. The open lane is identified by the decoy's byte appearing in the observed word. Base addresses include zero and the all-ones address, where the decoy location wraps to zero. Random access and read latencies, and a start pulse in the middle of a run, show that the access order and the results do not depend on timing.

// File: rtl/dbus_lane_pkg.sv
package dbus_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PAT,
        ST_WR_DECOY,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_FINISH
    } tester_state_e;

endpackage

// File: rtl/dbus_pattern_gen.sv
module dbus_pattern_gen #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 4
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] pattern_o
);
    localparam int HALF  = $clog2(DATA_W);
    localparam int NUM   = 2 * HALF;
    localparam int SEL_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic             invert;
    logic [SEL_W-1:0] sel;

    // Words NUM/2..NUM-1 mirror the first half and are inverted
    always_comb begin
        if (int'(idx_i) < HALF) begin
            invert = 1'b0;
            sel    = SEL_W'(idx_i);
        end else begin
            invert = 1'b1;
            sel    = SEL_W'(NUM - 1 - int'(idx_i));
        end
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        localparam logic [HALF-1:0] LANE_CODE = HALF'(g);
        assign pattern_o[g] = LANE_CODE[sel] ^ invert;
    end

    // R3: every generated word drives exactly half of the lines high
    always_comb begin
        if (int'(idx_i) < NUM)
            assert_balanced_word_R3: assert ($countones(pattern_o) == DATA_W / 2);
    end
endmodule

// File: rtl/dbus_fail_capture.sv
module dbus_fail_capture #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              cmp_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] obs_i,
    output logic              fail_o,
    output logic [ADDR_W-1:0] err_addr_o,
    output logic [DATA_W-1:0] err_exp_o,
    output logic [DATA_W-1:0] err_obs_o
);
    logic mismatch;
    assign mismatch = cmp_i && (exp_i != obs_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_o     <= 1'b0;
            err_addr_o <= '0;
            err_exp_o  <= '0;
            err_obs_o  <= '0;
        end else if (clear_i) begin
            fail_o     <= 1'b0;
            err_addr_o <= '0;
            err_exp_o  <= '0;
            err_obs_o  <= '0;
        end else if (mismatch && !fail_o) begin
            fail_o     <= 1'b1;
            err_addr_o <= addr_i;
            err_exp_o  <= exp_i;
            err_obs_o  <= obs_i;
        end
    end

    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o && !clear_i |=> fail_o);

    assert_first_err_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o && !clear_i |=> $stable(err_addr_o) && $stable(err_exp_o) && $stable(err_obs_o));

    assert_mismatch_sets_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch && !clear_i |=> fail_o);
endmodule

// File: rtl/dbus_lane_tester.sv
module dbus_lane_tester #(
    parameter int              DATA_W = 64,
    parameter int              ADDR_W = 16,
    parameter logic [DATA_W-1:0] DECOY = 64'h0123_4567_89AB_CDEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rvalid_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] err_addr_o,
    output logic [DATA_W-1:0] err_exp_o,
    output logic [DATA_W-1:0] err_obs_o
);
    import dbus_lane_pkg::*;

    localparam int NUM_WORDS = 2 * $clog2(DATA_W);
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    tester_state_e     state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] pattern;
    logic              start_acc;
    logic              cmp_strobe;
    logic [ADDR_W-1:0] decoy_addr;

    assign start_acc  = (state_q == ST_IDLE) && start_i;
    assign cmp_strobe = (state_q == ST_RD_WAIT) && mem_rvalid_i;
    assign decoy_addr = base_q + ADDR_W'(1);

    dbus_pattern_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) pat_gen_i (
        .idx_i     (idx_q),
        .pattern_o (pattern)
    );

    dbus_fail_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) capture_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_acc),
        .cmp_i      (cmp_strobe),
        .addr_i     (base_q),
        .exp_i      (pattern),
        .obs_i      (mem_rdata_i),
        .fail_o     (fail_o),
        .err_addr_o (err_addr_o),
        .err_exp_o  (err_exp_o),
        .err_obs_o  (err_obs_o)
    );

    // State register, word index and latched base
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start_acc) begin
                idx_q  <= '0;
                base_q <= base_addr_i;
            end else if (cmp_strobe && idx_q != LAST_IDX) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i)      state_d = ST_WR_PAT;
            ST_WR_PAT:   if (mem_ack_i)    state_d = ST_WR_DECOY;
            ST_WR_DECOY: if (mem_ack_i)    state_d = ST_RD_REQ;
            ST_RD_REQ:   if (mem_ack_i)    state_d = ST_RD_WAIT;
            ST_RD_WAIT:  if (mem_rvalid_i) state_d = (idx_q == LAST_IDX) ? ST_FINISH : ST_WR_PAT;
            ST_FINISH:                     state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = base_q;
        mem_wdata_o = '0;
        busy_o      = 1'b1;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:     busy_o = 1'b0;
            ST_WR_PAT: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = pattern;
            end
            ST_WR_DECOY: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = decoy_addr;
                mem_wdata_o = DECOY;
            end
            ST_RD_REQ:   mem_req_o = 1'b1;
            ST_RD_WAIT:  ;
            ST_FINISH:   done_o = 1'b1;
            default:     busy_o = 1'b0;
        endcase
    end

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o)
                                     && $stable(mem_addr_o) && $stable(mem_wdata_o));

    assert_read_after_decoy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && !$past(mem_req_o && !mem_we_o))
        |-> $past(mem_req_o && mem_we_o && mem_ack_i && mem_wdata_o == DECOY
                  && mem_addr_o == decoy_addr));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    assert_busy_until_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> busy_o);

    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> $stable(base_q));
endmodule

// File: tb/dbus_lane_tester_tb.sv
module dbus_lane_tester_tb_top;
    localparam int DW = 64;
    localparam int AW = 16;
    localparam logic [DW-1:0] DECOY_W = 64'h0123_4567_89AB_CDEF;
    localparam int LOGN = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_addr_i = '0;
    logic          mem_req_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic          mem_ack_i = 1'b0;
    logic [DW-1:0] mem_rdata_i = '0;
    logic          mem_rvalid_i = 1'b0;
    logic          busy_o, done_o, fail_o;
    logic [AW-1:0] err_addr_o;
    logic [DW-1:0] err_exp_o, err_obs_o;

    always #5 clk = ~clk;

    dbus_lane_tester #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .mem_rvalid_i(mem_rvalid_i), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .err_addr_o(err_addr_o), .err_exp_o(err_exp_o), .err_obs_o(err_obs_o)
    );

    // Memory model with stuck lines and an open-lane mask
    logic [DW-1:0] stuck1 = '0, stuck0 = '0, open_m = '0;
    logic [DW-1:0] store [int unsigned];
    logic [DW-1:0] last_bus = '0;
    logic          rd_pending = 1'b0;
    int            rd_cnt = 0, acc_cnt = 0;
    logic [DW-1:0] rd_val = '0;
    int            log_n = 0;
    logic          log_we   [LOGN];
    logic [AW-1:0] log_addr [LOGN];
    logic [DW-1:0] log_data [LOGN];

    always @(posedge clk) begin
        mem_ack_i    <= 1'b0;
        mem_rvalid_i <= 1'b0;
        if (rd_pending) begin
            if (rd_cnt == 0) begin
                mem_rvalid_i <= 1'b1;
                mem_rdata_i  <= rd_val;
                rd_pending   <= 1'b0;
            end else rd_cnt <= rd_cnt - 1;
        end else if (mem_req_o && !mem_ack_i) begin
            if (acc_cnt == 0) begin
                mem_ack_i <= 1'b1;
                acc_cnt   <= int'($urandom % 3);
                if (log_n < LOGN) begin
                    log_we[log_n]   <= mem_we_o;
                    log_addr[log_n] <= mem_addr_o;
                    log_data[log_n] <= mem_we_o ? mem_wdata_o : '0;
                end
                log_n <= log_n + 1;
                if (mem_we_o) begin
                    store[int'(mem_addr_o)] = (mem_wdata_o | stuck1) & ~stuck0;
                    last_bus <= mem_wdata_o;
                end else begin
                    rd_val     <= (store[int'(mem_addr_o)] & ~open_m) | (last_bus & open_m);
                    rd_pending <= 1'b1;
                    rd_cnt     <= int'($urandom % 4);
                end
            end else acc_cnt <= acc_cnt - 1;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit hung = 1'b0;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R3: reference test word computed from periods, not from lane codes
    function automatic logic [DW-1:0] ref_word(input int k);
        logic [DW-1:0] w;
        int j, period;
        j = (k < 6) ? k : 11 - k;
        period = 2 << j;
        for (int b = 0; b < DW; b++) w[b] = ((b % period) >= period / 2);
        return (k < 6) ? w : ~w;
    endfunction

    task automatic run_test(input logic [AW-1:0] base, input logic [DW-1:0] s1,
                            input logic [DW-1:0] s0, input logic [DW-1:0] om, input bit poke);
        int first, cyc, bad, fk;
        logic [DW-1:0] obs, fobs;
        if (hung) return;
        @(negedge clk);
        stuck1 = s1; stuck0 = s0; open_m = om;
        first = log_n;
        start_i = 1'b1; base_addr_i = base;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R10 busy after start", DW'(busy_o), 1);
        check(fail_o == 1'b0, "R9 fail cleared by start", DW'(fail_o), 0);
        cyc = 0;
        while (!done_o && cyc < 5000) begin
            if (poke && cyc == 40) begin start_i = 1'b1; base_addr_i = base ^ 16'h00F0; end
            else start_i = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        if (!done_o) begin
            check(1'b0, "R6 watchdog expired", DW'(cyc), 0);
            hung = 1'b1;
            return;
        end
        fk = -1; fobs = '0;
        for (int k = 0; k < 12; k++) begin
            obs = (((ref_word(k) | s1) & ~s0) & ~om) | (DECOY_W & om);
            if (fk < 0 && obs != ref_word(k)) begin fk = k; fobs = obs; end
        end
        check(fail_o == (fk >= 0), "R7 fail flag", DW'(fail_o), DW'(fk >= 0));
        if (fk >= 0) begin
            check(err_addr_o == base, "R8 error address", DW'(err_addr_o), DW'(base));
            check(err_exp_o == ref_word(fk), "R8 error expected word", err_exp_o, ref_word(fk));
            check(err_obs_o == fobs, "R8 error observed word", err_obs_o, fobs);
        end else begin
            check(err_obs_o == '0, "R8 no record without mismatch", err_obs_o, '0);
        end
        check((log_n - first) == 36, "R4 R6 accepted access count", DW'(log_n - first), 36);
        bad = 0;
        for (int k = 0; k < 12; k++) begin
            int p;
            p = first + 3 * k;
            if (p + 2 < LOGN) begin
                if (!(log_we[p] && log_addr[p] == base && log_data[p] == ref_word(k))) bad++;
                if (!(log_we[p+1] && log_addr[p+1] == AW'(base + 1) && log_data[p+1] == DECOY_W)) bad++;
                if (!(!log_we[p+2] && log_addr[p+2] == base)) bad++;
            end
        end
        check(bad == 0, poke ? "R2 R3 R4 access order with start during run" : "R3 R4 access order",
              DW'(bad), 0);
        @(negedge clk);
        check(done_o == 1'b0 && busy_o == 1'b0, "R6 R10 done single cycle then idle",
              DW'({done_o, busy_o}), 0);
    endtask

    initial begin
        logic [DW-1:0] hf_exp, hf_obs;
        logic hf;
        void'($urandom(32'h1357_2468));
        #23;
        check(mem_req_o == 0 && busy_o == 0 && done_o == 0 && fail_o == 0, "R1 reset outputs",
              DW'({mem_req_o, busy_o, done_o, fail_o}), 0);
        check(err_exp_o == 0 && err_obs_o == 0 && err_addr_o == 0, "R1 reset error record",
              err_exp_o | err_obs_o | DW'(err_addr_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy_o == 0 && mem_req_o == 0, "R1 idle without start", DW'({busy_o, mem_req_o}), 0);

        run_test(16'h0000, '0, '0, '0, 1'b0);                  // healthy, lowest base
        run_test(16'hFFFF, '0, '0, '0, 1'b0);                  // decoy wraps to zero
        run_test(16'h0120, 64'h0000_0000_0000_8000, '0, '0, 1'b0);  // line 15 stuck high
        run_test(16'h0342, '0, 64'h0000_0001_0000_0001, '0, 1'b0);  // two lines stuck low
        run_test(16'h0777, '0, '0, 64'h00FF_0000_0000_0000, 1'b0);  // open byte lane 55:48

        // R9: results hold after done
        hf = fail_o; hf_exp = err_exp_o; hf_obs = err_obs_o;
        repeat (25) @(negedge clk);
        check(fail_o == hf && err_exp_o == hf_exp && err_obs_o == hf_obs, "R9 results held after done",
              err_obs_o, hf_obs);
        check(err_obs_o[55:48] == 8'h23, "R8 open lane shows decoy byte", DW'(err_obs_o[55:48]), 64'h23);

        run_test(16'h0400, '0, '0, '0, 1'b1);                  // start pulse during run

        for (int r = 0; r < 8; r++) begin
            logic [DW-1:0] s1, s0, om;
            int mode, bitn;
            s1 = '0; s0 = '0; om = '0;
            mode = int'($urandom % 4);
            bitn = int'($urandom % DW);
            if (mode == 1) s1[bitn] = 1'b1;
            if (mode == 2) s0[bitn] = 1'b1;
            if (mode == 3) om = 64'hFF << (8 * (bitn % 8));
            run_test(AW'($urandom), s1, s0, om, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule